// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Entry

This block is the control front end of a small 8-bit microcontroller. It steps through three named states: FETCH, EXECUTE and INTERRUPT. It also decodes the 7-bit opcode held in the instruction register. From these it drives strobes for the program counter, the stack pointer, the shadow flag store and the interrupt mask. It does not touch any datapath value. The surrounding datapath acts on the strobes in the same clock edge that ends the cycle.

The instruction memory is synchronous. The word addressed by the program counter during FETCH therefore only appears on `opcode` in the following cycle. As a result, every instruction takes exactly one FETCH cycle and one EXECUTE cycle. The transitions are:
- FETCH always goes to EXECUTE.
- EXECUTE goes to FETCH, or to INTERRUPT when an unmasked request is present at that moment.
- INTERRUPT always goes back to FETCH after one cycle.

The INTERRUPT cycle does four things: it loads the program counter from the fixed top vector (address 0x3FF of the 10-bit space), pushes the return address, saves the flags and masks further requests.

The decoder knows two widths of operation code. Short codes use the upper five bits, and their two low bits are ignored. Full codes must match all seven bits. Only transfer-of-control instructions are decoded here. Any other opcode leaves every strobe inactive during EXECUTE.

Top module: `mcu_sequencer`

## Requirements
- R1: While `rst` is high, `pc_clr` and `mask_clr` are 1 and every other strobe is 0. The clock edge seen with `rst` high puts the sequencer in FETCH. `seq_state` encodes FETCH=0, EXECUTE=1, INTERRUPT=2.
- R2: FETCH always moves to EXECUTE at the next edge. In FETCH, the only strobe asserted is `pc_inc`.
- R3: In EXECUTE, if `irq` and `irq_en` are both 1, the next state is INTERRUPT; otherwise it is FETCH. `irq` has no effect in FETCH or INTERRUPT.
- R4: INTERRUPT lasts exactly one cycle and is followed by FETCH. It asserts `pc_load`, `pc_sel`=2 (fixed vector), `sp_dec`, `flag_save` and `mask_clr`, and nothing else.
- R5: Branch has upper five bits 5'b00100 (opcodes 0x10 to 0x13). In EXECUTE it asserts `pc_load` with `pc_sel`=0 (immediate) and nothing else.
- R6: Call has upper five bits 5'b00110 (opcodes 0x18 to 0x1B). In EXECUTE it asserts `pc_load` with `pc_sel`=0 and `sp_dec`, and nothing else.
- R7: Plain return is opcode 0x32. In EXECUTE it asserts `pc_load` with `pc_sel`=1 (stack) and `sp_inc`, and nothing else.
- R8: Return-with-enable is opcode 0x37. In EXECUTE it asserts the R7 strobes plus `flag_restore` and `mask_set`.
- R9: Return-with-disable is opcode 0x36. In EXECUTE it asserts the R7 strobes plus `flag_restore` and `mask_clr`, so interrupts stay masked.
- R10: Full 7-bit codes match exactly. Any opcode not listed in R5 to R9 (for example 0x33, 0x34, 0x14, 0x1C) asserts no strobe in EXECUTE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 7 | Operation code from the instruction register |
| irq | input | 1 | Interrupt request |
| irq_en | input | 1 | Current mask state, 1 = interrupts enabled |
| seq_state | output | 2 | Current state: 0 FETCH, 1 EXECUTE, 2 INTERRUPT |
| pc_clr | output | 1 | Clear the program counter to 0 |
| pc_inc | output | 1 | Increment the program counter |
| pc_load | output | 1 | Load the program counter from the selected source |
| pc_sel | output | 2 | Load source: 0 immediate, 1 stack, 2 fixed vector |
| sp_inc | output | 1 | Stack pointer increment (pop) |
| sp_dec | output | 1 | Stack pointer decrement (push) |
| flag_save | output | 1 | Copy flags into the shadow store |
| flag_restore | output | 1 | Copy shadow flags back to the flags |
| mask_set | output | 1 | Enable interrupts |
| mask_clr | output | 1 | Mask interrupts |

## Verification
The assertions assume the following about the inputs:
- `opcode`, `irq` and `irq_en` are fully known, with no X or Z values, at every rising edge after reset.
- `rst` is synchronous.
- `irq_en` reflects the mask as the surrounding logic holds it. The block only samples it in EXECUTE.

The stimulus changes all inputs only on the falling clock edge and always drives 0 or 1. It mixes two kinds of traffic. One kind is aligned instruction pairs that place each opcode family in the EXECUTE slot. The other is unaligned random traffic, which lands requests in every state, with masked and unmasked cases and with a reset in the middle of the run.

// File: rtl/mcu_seq_pkg.sv
package mcu_seq_pkg;

    typedef enum logic [1:0] {
        ST_FETCH = 2'd0,
        ST_EXEC  = 2'd1,
        ST_INTR  = 2'd2
    } seq_state_t;

    typedef enum logic [1:0] {
        PCSRC_IMM   = 2'd0,
        PCSRC_STACK = 2'd1,
        PCSRC_VEC   = 2'd2
    } pc_src_t;

    typedef enum logic [2:0] {
        INS_OTHER,
        INS_BRANCH,
        INS_CALL,
        INS_RET,
        INS_RETID,
        INS_RETIE
    } ins_kind_t;

    typedef struct packed {
        logic    pc_clr;
        logic    pc_inc;
        logic    pc_load;
        pc_src_t pc_sel;
        logic    sp_inc;
        logic    sp_dec;
        logic    flag_save;
        logic    flag_restore;
        logic    mask_set;
        logic    mask_clr;
    } ctl_t;

    localparam ctl_t CTL_IDLE = '0;

endpackage

// File: rtl/mcu_seq_opdec.sv
module mcu_seq_opdec
    import mcu_seq_pkg::*;
#(
    parameter int OP_W    = 7,
    parameter int SHORT_W = 5,
    parameter logic [SHORT_W-1:0] BRANCH_CODE = 5'b00100,
    parameter logic [SHORT_W-1:0] CALL_CODE   = 5'b00110,
    parameter logic [OP_W-1:0]    RET_CODE    = 7'h32,
    parameter logic [OP_W-1:0]    RETID_CODE  = 7'h36,
    parameter logic [OP_W-1:0]    RETIE_CODE  = 7'h37
) (
    input  logic [OP_W-1:0] opcode,
    output ins_kind_t       kind
);

    // Short codes compare only their upper field; low bits are don't-care.
    logic [SHORT_W-1:0] op_hi;
    assign op_hi = opcode[OP_W-1 -: SHORT_W];

    always_comb begin
        kind = INS_OTHER;
        if (opcode == RETIE_CODE) begin
            kind = INS_RETIE;
        end else if (opcode == RETID_CODE) begin
            kind = INS_RETID;
        end else if (opcode == RET_CODE) begin
            kind = INS_RET;
        end else if (op_hi == BRANCH_CODE) begin
            kind = INS_BRANCH;
        end else if (op_hi == CALL_CODE) begin
            kind = INS_CALL;
        end
    end

endmodule

// File: rtl/mcu_seq_next.sv
module mcu_seq_next
    import mcu_seq_pkg::*;
(
    input  seq_state_t state,
    input  logic       irq,
    input  logic       irq_en,
    output seq_state_t state_nxt
);

    always_comb begin
        unique case (state)
            ST_FETCH: state_nxt = ST_EXEC;
            ST_EXEC:  state_nxt = (irq && irq_en) ? ST_INTR : ST_FETCH;
            ST_INTR:  state_nxt = ST_FETCH;
            default:  state_nxt = ST_FETCH;
        endcase
    end

endmodule

// File: rtl/mcu_seq_outs.sv
module mcu_seq_outs
    import mcu_seq_pkg::*;
(
    input  logic       rst,
    input  seq_state_t state,
    input  ins_kind_t  kind,
    output ctl_t       ctl
);

    always_comb begin
        ctl = CTL_IDLE;
        if (rst) begin
            ctl.pc_clr   = 1'b1;
            ctl.mask_clr = 1'b1;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ctl.pc_inc = 1'b1;
                end
                ST_EXEC: begin
                    case (kind)
                        INS_BRANCH: begin
                            ctl.pc_load = 1'b1;
                            ctl.pc_sel  = PCSRC_IMM;
                        end
                        INS_CALL: begin
                            ctl.pc_load = 1'b1;
                            ctl.pc_sel  = PCSRC_IMM;
                            ctl.sp_dec  = 1'b1;
                        end
                        INS_RET: begin
                            ctl.pc_load = 1'b1;
                            ctl.pc_sel  = PCSRC_STACK;
                            ctl.sp_inc  = 1'b1;
                        end
                        INS_RETID: begin
                            ctl.pc_load      = 1'b1;
                            ctl.pc_sel       = PCSRC_STACK;
                            ctl.sp_inc       = 1'b1;
                            ctl.flag_restore = 1'b1;
                            ctl.mask_clr     = 1'b1;
                        end
                        INS_RETIE: begin
                            ctl.pc_load      = 1'b1;
                            ctl.pc_sel       = PCSRC_STACK;
                            ctl.sp_inc       = 1'b1;
                            ctl.flag_restore = 1'b1;
                            ctl.mask_set     = 1'b1;
                        end
                        default: ctl = CTL_IDLE;
                    endcase
                end
                ST_INTR: begin
                    ctl.pc_load   = 1'b1;
                    ctl.pc_sel    = PCSRC_VEC;
                    ctl.sp_dec    = 1'b1;
                    ctl.flag_save = 1'b1;
                    ctl.mask_clr  = 1'b1;
                end
                default: ctl = CTL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mcu_sequencer.sv
module mcu_sequencer
    import mcu_seq_pkg::*;
#(
    parameter int OP_W    = 7,
    parameter int SHORT_W = 5,
    parameter logic [SHORT_W-1:0] BRANCH_CODE = 5'b00100,
    parameter logic [SHORT_W-1:0] CALL_CODE   = 5'b00110,
    parameter logic [OP_W-1:0]    RET_CODE    = 7'h32,
    parameter logic [OP_W-1:0]    RETID_CODE  = 7'h36,
    parameter logic [OP_W-1:0]    RETIE_CODE  = 7'h37
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] opcode,
    input  logic            irq,
    input  logic            irq_en,
    output logic [1:0]      seq_state,
    output logic            pc_clr,
    output logic            pc_inc,
    output logic            pc_load,
    output logic [1:0]      pc_sel,
    output logic            sp_inc,
    output logic            sp_dec,
    output logic            flag_save,
    output logic            flag_restore,
    output logic            mask_set,
    output logic            mask_clr
);

    seq_state_t state_q;
    seq_state_t state_d;
    ins_kind_t  kind;
    ctl_t       ctl;

    mcu_seq_opdec #(
        .OP_W        (OP_W),
        .SHORT_W     (SHORT_W),
        .BRANCH_CODE (BRANCH_CODE),
        .CALL_CODE   (CALL_CODE),
        .RET_CODE    (RET_CODE),
        .RETID_CODE  (RETID_CODE),
        .RETIE_CODE  (RETIE_CODE)
    ) u_opdec (
        .opcode (opcode),
        .kind   (kind)
    );

    mcu_seq_next u_next (
        .state     (state_q),
        .irq       (irq),
        .irq_en    (irq_en),
        .state_nxt (state_d)
    );

    mcu_seq_outs u_outs (
        .rst   (rst),
        .state (state_q),
        .kind  (kind),
        .ctl   (ctl)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FETCH;
        end else begin
            state_q <= state_d;
        end
    end

    assign seq_state    = state_q;
    assign pc_clr       = ctl.pc_clr;
    assign pc_inc       = ctl.pc_inc;
    assign pc_load      = ctl.pc_load;
    assign pc_sel       = ctl.pc_sel;
    assign sp_inc       = ctl.sp_inc;
    assign sp_dec       = ctl.sp_dec;
    assign flag_save    = ctl.flag_save;
    assign flag_restore = ctl.flag_restore;
    assign mask_set     = ctl.mask_set;
    assign mask_clr     = ctl.mask_clr;

endmodule

// File: rtl/mcu_seq_checker.sv
module mcu_seq_checker #(
    parameter int OP_W    = 7,
    parameter int SHORT_W = 5,
    parameter logic [SHORT_W-1:0] BRANCH_CODE = 5'b00100,
    parameter logic [OP_W-1:0]    RET_CODE    = 7'h32,
    parameter logic [OP_W-1:0]    RETIE_CODE  = 7'h37
) (
    input logic            clk,
    input logic            rst,
    input logic [OP_W-1:0] opcode,
    input logic            irq,
    input logic            irq_en,
    input logic [1:0]      seq_state,
    input logic            pc_clr,
    input logic            pc_inc,
    input logic            pc_load,
    input logic [1:0]      pc_sel,
    input logic            sp_inc,
    input logic            sp_dec,
    input logic            flag_save,
    input logic            flag_restore,
    input logic            mask_set,
    input logic            mask_clr
);

    assert_reset_outs_R1: assert property (@(posedge clk)
        rst |-> (pc_clr && mask_clr && !pc_inc && !pc_load && !sp_inc && !sp_dec
                 && !flag_save && !flag_restore && !mask_set));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (seq_state == 2'd0));

    assert_fetch_to_exec_R2: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd0) |=> (seq_state == 2'd1));

    assert_irq_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && irq && irq_en) |=> (seq_state == 2'd2));

    assert_no_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && !(irq && irq_en)) |=> (seq_state == 2'd0));

    assert_intr_single_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd2) |=> (seq_state == 2'd0));

    assert_intr_outs_R4: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd2) |-> (pc_load && pc_sel == 2'd2 && sp_dec && flag_save && mask_clr));

    assert_branch_R5: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && opcode[OP_W-1 -: SHORT_W] == BRANCH_CODE)
            |-> (pc_load && pc_sel == 2'd0 && !sp_dec && !sp_inc));

    assert_ret_R7: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && opcode == RET_CODE)
            |-> (pc_load && pc_sel == 2'd1 && sp_inc && !flag_restore));

    assert_retie_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_state == 2'd1 && opcode == RETIE_CODE)
            |-> (mask_set && flag_restore && sp_inc));

    assert_sp_onehot_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sp_inc, sp_dec}));

    assert_mask_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(mask_set && mask_clr));

    assert_state_legal_R1: assert property (@(posedge clk) disable iff (rst)
        (seq_state != 2'd3));

endmodule

bind mcu_sequencer mcu_seq_checker #(
    .OP_W        (OP_W),
    .SHORT_W     (SHORT_W),
    .BRANCH_CODE (BRANCH_CODE),
    .RET_CODE    (RET_CODE),
    .RETIE_CODE  (RETIE_CODE)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .opcode       (opcode),
    .irq          (irq),
    .irq_en       (irq_en),
    .seq_state    (seq_state),
    .pc_clr       (pc_clr),
    .pc_inc       (pc_inc),
    .pc_load      (pc_load),
    .pc_sel       (pc_sel),
    .sp_inc       (sp_inc),
    .sp_dec       (sp_dec),
    .flag_save    (flag_save),
    .flag_restore (flag_restore),
    .mask_set     (mask_set),
    .mask_clr     (mask_clr)
);

// File: tb/tb_mcu_sequencer.sv
`timescale 1ns/1ps
module tb_mcu_sequencer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] opcode = 7'h00;
    logic       irq = 1'b0;
    logic       irq_en = 1'b0;
    logic [1:0] seq_state;
    logic       pc_clr, pc_inc, pc_load, sp_inc, sp_dec;
    logic [1:0] pc_sel;
    logic       flag_save, flag_restore, mask_set, mask_clr;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    int m_state = -1;   // -1: unknown before first reset edge
    string st_tag = "R1";

    always #2.5 clk = ~clk;

    mcu_sequencer dut (
        .clk(clk), .rst(rst), .opcode(opcode), .irq(irq), .irq_en(irq_en),
        .seq_state(seq_state), .pc_clr(pc_clr), .pc_inc(pc_inc),
        .pc_load(pc_load), .pc_sel(pc_sel), .sp_inc(sp_inc), .sp_dec(sp_dec),
        .flag_save(flag_save), .flag_restore(flag_restore),
        .mask_set(mask_set), .mask_clr(mask_clr)
    );

    // Packing order: clr, inc, load, sel[1:0], spi, spd, fsave, frest, mset, mclr
    function automatic logic [10:0] pack(input logic c, input logic i, input logic l,
                                         input logic [1:0] s, input logic a, input logic d,
                                         input logic fs, input logic fr,
                                         input logic ms, input logic mc);
        return {c, i, l, s, a, d, fs, fr, ms, mc};
    endfunction

    task automatic step(input logic r, input logic [6:0] op, input logic q, input logic en);
        logic [10:0] exp_v;
        logic [10:0] act_v;
        string tag;
        int hi;
        @(negedge clk);
        rst = r; opcode = op; irq = q; irq_en = en;
        #1;
        hi = int'(op) >> 2;
        exp_v = '0;
        tag = "R10";
        if (r) begin
            exp_v = pack(1, 0, 0, 2'd0, 0, 0, 0, 0, 0, 1); tag = "R1";
        end else if (m_state == 0) begin
            exp_v = pack(0, 1, 0, 2'd0, 0, 0, 0, 0, 0, 0); tag = "R2";
        end else if (m_state == 2) begin
            exp_v = pack(0, 0, 1, 2'd2, 0, 1, 1, 0, 0, 1); tag = "R4";
        end else if (op == 7'h37) begin
            exp_v = pack(0, 0, 1, 2'd1, 1, 0, 0, 1, 1, 0); tag = "R8";
        end else if (op == 7'h36) begin
            exp_v = pack(0, 0, 1, 2'd1, 1, 0, 0, 1, 0, 1); tag = "R9";
        end else if (op == 7'h32) begin
            exp_v = pack(0, 0, 1, 2'd1, 1, 0, 0, 0, 0, 0); tag = "R7";
        end else if (hi == 4) begin
            exp_v = pack(0, 0, 1, 2'd0, 0, 0, 0, 0, 0, 0); tag = "R5";
        end else if (hi == 6) begin
            exp_v = pack(0, 0, 1, 2'd0, 0, 1, 0, 0, 0, 0); tag = "R6";
        end
        act_v = pack(pc_clr, pc_inc, pc_load, pc_sel, sp_inc, sp_dec,
                     flag_save, flag_restore, mask_set, mask_clr);
        checks++;
        if (act_v !== exp_v) begin
            errors++;
            $display("FAIL %s: strobes=%h expected=%h (state %0d opcode %h)",
                     tag, act_v, exp_v, m_state, op);
        end
        if (m_state >= 0) begin
            checks++;
            if (seq_state !== 2'(m_state)) begin
                errors++;
                $display("FAIL %s: seq_state=%0d expected=%0d", st_tag, seq_state, m_state);
            end
        end
        // Model of the next edge
        if (r) begin
            m_state = 0; st_tag = "R1";
        end else if (m_state == 0) begin
            m_state = 1; st_tag = "R2";
        end else if (m_state == 1) begin
            m_state = (q && en) ? 2 : 0; st_tag = "R3";
        end else begin
            m_state = 0; st_tag = "R4";
        end
    endtask

    // One instruction: fetch then execute, plus interrupt cycle if taken
    task automatic instr(input logic [6:0] op, input logic q, input logic en);
        step(0, op, 0, en);
        step(0, op, q, en);
        if (q && en) step(0, 7'h00, 0, 0);
    endtask

    initial begin
        logic [6:0] pick [12] = '{7'h10, 7'h13, 7'h18, 7'h1B, 7'h32, 7'h36,
                                  7'h37, 7'h33, 7'h14, 7'h1C, 7'h00, 7'h7F};
        // R1: reset
        repeat (3) step(1, 7'h37, 1, 1);
        // R5: branch with every low-bit pattern
        for (int k = 0; k < 4; k++) instr(7'h10 + 7'(k), 0, 1);
        // R6: call with every low-bit pattern
        for (int k = 0; k < 4; k++) instr(7'h18 + 7'(k), 0, 1);
        // R7, R8, R9
        instr(7'h32, 0, 1);
        instr(7'h37, 0, 0);
        instr(7'h36, 0, 0);
        // R10: neighbours of full codes and of short groups
        instr(7'h33, 0, 1); instr(7'h34, 0, 1); instr(7'h30, 0, 1);
        instr(7'h35, 0, 1); instr(7'h14, 0, 1); instr(7'h1C, 0, 1);
        instr(7'h0F, 0, 1); instr(7'h7F, 0, 1);
        // R3: request during fetch only is ignored
        step(0, 7'h00, 1, 1);
        step(0, 7'h00, 0, 1);
        // R3: masked request in execute is ignored
        instr(7'h10, 1, 0);
        // R3, R4: unmasked request in execute enters interrupt
        instr(7'h00, 1, 1);
        instr(7'h18, 1, 1);
        instr(7'h37, 1, 1);
        // R3: request held through interrupt cycle has no effect there
        step(0, 7'h00, 0, 1);
        step(0, 7'h00, 1, 1);
        step(0, 7'h00, 1, 1);
        step(0, 7'h00, 1, 1);
        // Unaligned random traffic with a reset in the middle
        for (int n = 0; n < 3000; n++) begin
            int idx;
            idx = int'($urandom_range(0, 11));
            step((n == 1500) ? 1'b1 : 1'b0, pick[idx], 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)));
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule